// File: doc/BRIEF.md
# Weighted Multi-Class Link Scheduler

This block decides which of several per-class packet queues may transmit next on a single output link. Each queue reports whether it holds a packet and how many bytes its head packet has. The scheduler grants the link to one queue at a time. It keeps that grant until the transmitter signals, with a one-cycle done strobe, that the packet has left. Queue storage, transmit timing and rate policing are outside the block.

A configuration bit selects between two service disciplines. In strict-priority mode the lowest-numbered non-empty queue always wins, so lower classes wait for as long as higher ones stay backlogged. In weighted mode the block runs a deficit round-robin over the queues. Each visit credits the queue with its programmed byte quantum, and the queue keeps sending while its head packet fits in the credit it holds. Each class therefore receives a share of link bytes in proportion to its quantum, and the link never idles while any queue has a packet. A queue that runs dry loses its remaining credit, so it cannot save up bandwidth while idle. A change of mode applies only between packets.

Top module: `wls_link_sched`

## Requirements
- R1: After reset no queue is granted (grant_o = 0, grant_valid_o = 0), every queue's credit is zero, and the weighted walk starts its first visit at queue 0.
- R2: grant_o is one-hot or zero, grant_valid_o is high exactly while it is non-zero, and a grant is only issued to a queue whose q_ready_i bit was set in the cycle the decision was taken.
- R3: A grant stays unchanged until tx_done_i is sampled high. It is released on that edge, so grant_valid_o is low in the following cycle. tx_done_i while nothing is granted has no effect.
- R4: In strict mode (strict_mode_i = 1) the grant goes to the lowest-index non-empty queue (queue 0 is the highest priority), so a lower queue is served only when all queues above it are empty.
- R5: In weighted mode queues are visited in ascending index order, wrapping from NQ-1 to 0. On arriving at a non-empty queue its quantum (q_quantum_i bits [i*QW +: QW]) is added to its credit. Its head packet (length q_head_len_i bits [i*LEN_W +: LEN_W]) is granted if that length is no more than the credit, and the length is subtracted when done arrives. The walk moves on when the queue is empty or its head packet no longer fits.
- R6: With all queues backlogged with equal-length packets, bytes served follow the quanta. With quanta 500/300/200/100 and 100-byte packets, the first 11 grants split 5/3/2/1 over queues 0..3.
- R7: A queue's credit is cleared whenever that queue is empty and not currently granted, so credit left over before it emptied is not usable later.
- R8: In weighted mode, when every quantum is at least as large as every head length, a non-empty queue is granted no more than 2*NQ+1 cycles after the link becomes free.
- R9: strict_mode_i is only consulted when choosing a new packet: toggling it during a grant changes nothing until done. Packets served in strict mode leave weighted-mode credits and the walk position untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| strict_mode_i | input | 1 | 1 = strict priority, 0 = weighted deficit round-robin |
| q_ready_i | input | NQ | Bit i set when queue i holds at least one packet |
| q_head_len_i | input | NQ*LEN_W | Byte length of each queue's head packet, queue i at [i*LEN_W +: LEN_W] |
| q_quantum_i | input | NQ*QW | Byte quantum of each queue per weighted visit, queue i at [i*QW +: QW] |
| tx_done_i | input | 1 | One-cycle strobe: the granted packet has been fully sent |
| grant_o | output | NQ | One-hot grant to the queue currently owning the link |
| grant_valid_o | output | 1 | High while a grant is outstanding |

## Verification
A corrupted credit counter or walk pointer does not cause an immediate port error. It changes which queue wins the next weighted decision, so it first shows as a wrong grant index at the next packet boundary, within a few cycles of the preceding done. The bench therefore predicts every grant from its own transaction-level model and compares each one. A wrong busy flag shows within one cycle, either as a grant that changes before done or one that survives it. A priority error shows on the first strict decision where two queues are non-empty.

// File: rtl/wls_pkg.sv
// Package: shared types for the weighted link scheduler.
// Assumes nothing beyond IEEE 1800-2017 packages.
package wls_pkg;
    // Link ownership state of the scheduler.
    typedef enum logic [0:0] {
        LINK_FREE = 1'b0,
        LINK_HELD = 1'b1
    } link_state_e;
endpackage

// File: rtl/wls_first_set.sv
// Module: wls_first_set
// Finds the lowest set bit of a vector (the highest-priority requester).
// Assumes IW >= $clog2(N); purely combinational.
module wls_first_set #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the top so the lowest index wins last.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wls_credit_bank.sv
// Module: wls_credit_bank
// Holds one byte-credit counter per queue. A counter is cleared while its
// queue is empty and not granted, gains the quantum on a walk visit, and
// loses the packet length when a weighted packet completes.
// Assumes callers never subtract more than the counter holds and DW is
// wide enough for quantum plus one maximum packet.
module wls_credit_bank #(
    parameter int NQ    = 4,
    parameter int IW    = 2,
    parameter int LEN_W = 11,
    parameter int QW    = 11,
    parameter int DW    = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    q_ready_i,
    input  logic [NQ*QW-1:0] quantum_i,
    input  logic             add_en_i,
    input  logic [IW-1:0]    add_idx_i,
    input  logic             sub_en_i,
    input  logic [IW-1:0]    sub_idx_i,
    input  logic [LEN_W-1:0] sub_amt_i,
    input  logic             hold_en_i,
    input  logic [IW-1:0]    hold_idx_i,
    output logic [NQ*DW-1:0] credit_o
);
    generate
        for (genvar g = 0; g < NQ; g++) begin : g_cnt
            logic [DW-1:0] cnt_q;
            logic          held;
            logic [DW-1:0] qnt;
            logic [DW-1:0] amt;

            // Decode per-queue controls and widen operands.
            always_comb begin
                held = hold_en_i && (hold_idx_i == IW'(g));
                qnt  = {{(DW - QW){1'b0}}, quantum_i[g*QW +: QW]};
                amt  = {{(DW - LEN_W){1'b0}}, sub_amt_i};
            end

            // Update the credit of queue g.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!q_ready_i[g] && !held) begin
                    cnt_q <= '0;
                end else if (add_en_i && add_idx_i == IW'(g)) begin
                    cnt_q <= cnt_q + qnt;
                end else if (sub_en_i && sub_idx_i == IW'(g)) begin
                    cnt_q <= cnt_q - amt;
                end
            end

            assign credit_o[g*DW +: DW] = cnt_q;
        end
    endgenerate
endmodule

// File: rtl/wls_rotor.sv
// Module: wls_rotor
// Walks the queues for weighted service, one action per enabled cycle:
// skip an empty queue, credit a newly visited queue, grant a fitting head
// packet, or leave a queue whose head does not fit.
// Assumes step_i is only raised while the link is free, weighted mode is
// selected and at least one queue is non-empty.
module wls_rotor #(
    parameter int NQ    = 4,
    parameter int IW    = 2,
    parameter int LEN_W = 11,
    parameter int DW    = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic [NQ-1:0]       q_ready_i,
    input  logic [NQ*LEN_W-1:0] head_len_i,
    input  logic [NQ*DW-1:0]    credit_i,
    output logic                add_o,
    output logic                pick_o,
    output logic [IW-1:0]       sel_o
);
    logic [IW-1:0]    ptr_q;
    logic             fresh_q;
    logic             here_ready;
    logic [DW-1:0]    here_len;
    logic [DW-1:0]    here_cred;
    logic             fits;
    logic             move;

    // Look at the queue under the pointer and choose this cycle's action.
    always_comb begin
        here_ready = q_ready_i[ptr_q];
        here_len   = {{(DW - LEN_W){1'b0}}, head_len_i[int'(ptr_q)*LEN_W +: LEN_W]};
        here_cred  = credit_i[int'(ptr_q)*DW +: DW];
        fits       = here_len <= here_cred;
        add_o      = step_i && here_ready && fresh_q;
        pick_o     = step_i && here_ready && !fresh_q && fits;
        move       = step_i && (!here_ready || (!fresh_q && !fits));
        sel_o      = ptr_q;
    end

    // Advance the pointer and track whether the current visit was credited.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            fresh_q <= 1'b1;
        end else if (move) begin
            ptr_q   <= (ptr_q == IW'(NQ - 1)) ? '0 : ptr_q + 1'b1;
            fresh_q <= 1'b1;
        end else if (add_o) begin
            fresh_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wls_link_sched.sv
// Module: wls_link_sched (top)
// Grants one output link to one of NQ class queues at a time, either by
// strict priority (queue 0 first) or by byte-weighted deficit round-robin.
// A grant is held until tx_done_i; decisions, including the mode choice,
// are made only while the link is free.
// Assumes NQ >= 2, every quantum non-zero in weighted mode, and that a
// granted queue stays non-empty until its done strobe.
module wls_link_sched
    import wls_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int LEN_W = 11,
    parameter int QW    = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strict_mode_i,
    input  logic [NQ-1:0]       q_ready_i,
    input  logic [NQ*LEN_W-1:0] q_head_len_i,
    input  logic [NQ*QW-1:0]    q_quantum_i,
    input  logic                tx_done_i,
    output logic [NQ-1:0]       grant_o,
    output logic                grant_valid_o
);
    localparam int IW = $clog2(NQ);
    localparam int DW = ((LEN_W > QW) ? LEN_W : QW) + 2;

    link_state_e      state_q;
    logic [IW-1:0]    cur_q;
    logic [LEN_W-1:0] cur_len_q;
    logic             cur_wrr_q;

    logic             any_ready;
    logic             free;
    logic             prio_found;
    logic [IW-1:0]    prio_idx;
    logic             rot_step;
    logic             rot_add;
    logic             rot_pick;
    logic [IW-1:0]    rot_sel;
    logic             launch;
    logic [IW-1:0]    launch_idx;
    logic             finish;
    logic [NQ*DW-1:0] credit;

    // Decision inputs: link free, anything waiting, which discipline acts.
    always_comb begin
        any_ready  = |q_ready_i;
        free       = (state_q == LINK_FREE);
        rot_step   = free && !strict_mode_i && any_ready;
        launch     = free && (strict_mode_i ? prio_found : rot_pick);
        launch_idx = strict_mode_i ? prio_idx : rot_sel;
        finish     = !free && tx_done_i;
    end

    wls_first_set #(
        .N  (NQ),
        .IW (IW)
    ) prio_i (
        .vec_i   (q_ready_i),
        .found_o (prio_found),
        .idx_o   (prio_idx)
    );

    wls_rotor #(
        .NQ    (NQ),
        .IW    (IW),
        .LEN_W (LEN_W),
        .DW    (DW)
    ) rotor_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (rot_step),
        .q_ready_i  (q_ready_i),
        .head_len_i (q_head_len_i),
        .credit_i   (credit),
        .add_o      (rot_add),
        .pick_o     (rot_pick),
        .sel_o      (rot_sel)
    );

    wls_credit_bank #(
        .NQ    (NQ),
        .IW    (IW),
        .LEN_W (LEN_W),
        .QW    (QW),
        .DW    (DW)
    ) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_ready_i  (q_ready_i),
        .quantum_i  (q_quantum_i),
        .add_en_i   (rot_add),
        .add_idx_i  (rot_sel),
        .sub_en_i   (finish && cur_wrr_q),
        .sub_idx_i  (cur_q),
        .sub_amt_i  (cur_len_q),
        .hold_en_i  (!free),
        .hold_idx_i (cur_q),
        .credit_o   (credit)
    );

    // Track link ownership and capture the granted packet's details.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LINK_FREE;
            cur_q     <= '0;
            cur_len_q <= '0;
            cur_wrr_q <= 1'b0;
        end else if (launch) begin
            state_q   <= LINK_HELD;
            cur_q     <= launch_idx;
            cur_len_q <= q_head_len_i[int'(launch_idx)*LEN_W +: LEN_W];
            cur_wrr_q <= !strict_mode_i;
        end else if (finish) begin
            state_q   <= LINK_FREE;
        end
    end

    // Drive the one-hot grant from the held owner.
    always_comb begin
        grant_valid_o = !free;
        grant_o       = free ? '0 : (NQ'(1) << cur_q);
    end
endmodule

// File: rtl/wls_link_sched_chk.sv
// Module: wls_link_sched_chk
// Port-level protocol checks for wls_link_sched, attached with bind.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module wls_link_sched_chk #(
    parameter int NQ = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strict_mode_i,
    input logic [NQ-1:0] q_ready_i,
    input logic          tx_done_i,
    input logic [NQ-1:0] grant_o,
    input logic          grant_valid_o
);
    // R2: at most one grant, and valid tracks it.
    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

    // R2: a new grant targets a queue that was non-empty at decision time.
    assert_grant_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid_o) |-> ((grant_o & $past(q_ready_i)) != '0));

    // R3: grant is held unchanged until done.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !tx_done_i) |=> (grant_valid_o && $stable(grant_o)));

    // R3: done releases the link for at least one cycle.
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && tx_done_i) |=> !grant_valid_o);

    // R3: with nothing waiting and nothing granted, no grant appears.
    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid_o && q_ready_i == '0) |=> !grant_valid_o);

    // R4: a strict decision picks the lowest non-empty queue.
    assert_strict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_valid_o) && $past(strict_mode_i)) |->
        (grant_o == ($past(q_ready_i) & (~$past(q_ready_i) + 1'b1))));
endmodule

bind wls_link_sched wls_link_sched_chk #(.NQ(NQ)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .strict_mode_i (strict_mode_i),
    .q_ready_i     (q_ready_i),
    .tx_done_i     (tx_done_i),
    .grant_o       (grant_o),
    .grant_valid_o (grant_valid_o)
);

// File: tb/wls_link_sched_tb_top.sv
// Bench for wls_link_sched: bench-side queues feed the design, and a
// transaction-level model predicts each grant from the requirements.
module wls_link_sched_tb_top;
    localparam int NQ    = 4;
    localparam int LEN_W = 11;
    localparam int QW    = 11;
    localparam int CAP   = 64;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                strict_mode = 1'b0;
    logic [NQ-1:0]       q_ready;
    logic [NQ*LEN_W-1:0] q_head_len;
    logic [NQ*QW-1:0]    q_quantum;
    logic                tx_done = 1'b0;
    logic [NQ-1:0]       grant;
    logic                grant_valid;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    int qlen [NQ][CAP];
    int qhd  [NQ];
    int qcnt [NQ];
    int qqnt [NQ];

    int m_def [NQ];
    int m_ptr;
    bit m_fresh;

    always #5 clk = ~clk;

    wls_link_sched #(.NQ(NQ), .LEN_W(LEN_W), .QW(QW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .strict_mode_i (strict_mode),
        .q_ready_i     (q_ready),
        .q_head_len_i  (q_head_len),
        .q_quantum_i   (q_quantum),
        .tx_done_i     (tx_done),
        .grant_o       (grant),
        .grant_valid_o (grant_valid)
    );

    // Present bench queue heads to the design.
    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            q_ready[i] = qcnt[i] > 0;
            q_head_len[i*LEN_W +: LEN_W] = (qcnt[i] > 0) ? LEN_W'(qlen[i][qhd[i]]) : '0;
            q_quantum[i*QW +: QW] = QW'(qqnt[i]);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int head(input int q);
        return qlen[q][qhd[q]];
    endfunction

    task automatic push(input int q, input int len);
        qlen[q][qhd[q] + qcnt[q]] = len;
        qcnt[q]++;
    endtask

    // Clear bench queues and model, apply reset for two cycles.
    task automatic do_reset(input bit strict);
        @(negedge clk);
        rst_n = 1'b0;
        tx_done = 1'b0;
        strict_mode = strict;
        for (int i = 0; i < NQ; i++) begin
            qhd[i] = 0; qcnt[i] = 0; m_def[i] = 0; qqnt[i] = 1;
        end
        m_ptr = 0;
        m_fresh = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Predict the next grant from the requirements.
    function automatic int model_pick(input bit strict);
        if (strict) begin
            for (int i = 0; i < NQ; i++) if (qcnt[i] > 0) return i;
            return -1;
        end
        for (int guard = 0; guard < 10000; guard++) begin
            if (qcnt[m_ptr] == 0) begin
                m_def[m_ptr] = 0;
                m_ptr = (m_ptr + 1) % NQ;
                m_fresh = 1'b1;
            end else if (m_fresh) begin
                m_def[m_ptr] += qqnt[m_ptr];
                m_fresh = 1'b0;
            end else if (head(m_ptr) <= m_def[m_ptr]) begin
                return m_ptr;
            end else begin
                m_ptr = (m_ptr + 1) % NQ;
                m_fresh = 1'b1;
            end
        end
        return -1;
    endfunction

    // Wait for a grant, compare it with the model, hold, then finish it.
    task automatic serve(input int hold, input int new_mode, input bit gap_chk,
                         input string req, output int g);
        int gap = 0;
        int exp;
        bit wrr;
        logic [NQ-1:0] seen;
        while (!grant_valid && gap < 500) begin
            @(negedge clk);
            gap++;
        end
        wrr = !strict_mode;
        exp = model_pick(strict_mode);
        g = -1;
        for (int i = 0; i < NQ; i++) if (grant[i]) g = i;
        chk(grant_valid && $onehot(grant) && g == exp, req, g, exp);
        if (gap_chk) chk(gap <= 2 * NQ + 1, "R8 grant latency", gap, 2 * NQ + 1);
        if (g < 0) g = (exp < 0) ? 0 : exp;
        seen = grant;
        for (int h = 0; h < hold; h++) begin
            if (h == 1 && new_mode >= 0) strict_mode = new_mode[0];
            @(negedge clk);
        end
        chk(grant == seen && grant_valid, (new_mode >= 0) ? "R9 grant kept over mode change" : "R3 grant held",
            int'(grant), int'(seen));
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        chk(!grant_valid, "R3 release after done", int'(grant_valid), 0);
        if (wrr) m_def[g] -= head(g);
        qhd[g]++;
        qcnt[g]--;
        if (qcnt[g] == 0) m_def[g] = 0;
    endtask

    task automatic drain(input bit gap_chk, input string req);
        int g;
        int left = 0;
        for (int i = 0; i < NQ; i++) left += qcnt[i];
        for (int k = 0; k < left; k++) serve(1 + (k % 3), -1, gap_chk, req, g);
    endtask

    // Watchdog: a hung run is a failure but still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int g;
        int cnt [NQ];
        for (int i = 0; i < NQ; i++) begin qhd[i] = 0; qcnt[i] = 0; qqnt[i] = 1; end

        // R1: reset state.
        do_reset(1'b0);
        @(negedge clk);
        chk(grant_valid == 1'b0 && grant == '0, "R1 reset idle", int'(grant), 0);

        // R3: done while idle and empty has no effect.
        tx_done = 1'b1;
        repeat (3) @(negedge clk);
        tx_done = 1'b0;
        @(negedge clk);
        chk(!grant_valid, "R3 idle done ignored", int'(grant_valid), 0);
        // R1: first weighted walk starts at queue 0 with zero credit.
        for (int i = 0; i < NQ; i++) begin qqnt[i] = 300; push(i, 200); push(i, 200); end
        serve(2, -1, 1'b1, "R1 first visit queue 0", g);
        drain(1'b1, "R5 weighted order");

        // R4: strict priority, lower queues starve while higher are backlogged.
        do_reset(1'b1);
        push(3, 60); push(1, 70); push(1, 80); push(2, 90); push(0, 40); push(0, 50); push(1, 30);
        for (int k = 0; k < 7; k++) serve(2, -1, 1'b0, "R4 strict order", g);
        chk(qcnt[3] == 0, "R4 lowest class drained last", qcnt[3], 0);

        // R6: byte shares follow quanta 500/300/200/100.
        do_reset(1'b0);
        qqnt[0] = 500; qqnt[1] = 300; qqnt[2] = 200; qqnt[3] = 100;
        for (int i = 0; i < NQ; i++) begin
            cnt[i] = 0;
            for (int k = 0; k < 8; k++) push(i, 100);
        end
        for (int k = 0; k < 11; k++) begin
            serve(1, -1, 1'b1, "R6 weighted share order", g);
            cnt[g]++;
        end
        chk(cnt[0] == 5, "R6 share queue 0", cnt[0], 5);
        chk(cnt[1] == 3, "R6 share queue 1", cnt[1], 3);
        chk(cnt[2] == 2, "R6 share queue 2", cnt[2], 2);
        chk(cnt[3] == 1, "R6 share queue 3", cnt[3], 1);
        drain(1'b1, "R6 weighted tail");

        // R5: sweep quantum sets against length patterns.
        for (int qs = 0; qs < 3; qs++) begin
            for (int lp = 0; lp < 3; lp++) begin
                do_reset(1'b0);
                for (int i = 0; i < NQ; i++) begin
                    case (qs)
                        0: qqnt[i] = 300;
                        1: qqnt[i] = 1500 - i * 450;
                        default: qqnt[i] = 100 + ((i * 7) % 4) * 350;
                    endcase
                    for (int k = 0; k < 6; k++)
                        push(i, 40 + ((k * 37 + i * 91 + lp * 53) % ((lp == 0) ? 200 : 1460)));
                end
                drain(1'b0, "R5 deficit sweep");
            end
        end

        // R8: single backlogged queue, others idle, link stays busy.
        do_reset(1'b0);
        for (int i = 0; i < NQ; i++) qqnt[i] = 1500;
        for (int k = 0; k < 5; k++) push(2, 1400 - k * 100);
        drain(1'b1, "R8 lone queue");

        // R7: leftover credit is dropped when a queue empties.
        do_reset(1'b0);
        qqnt[0] = 200; qqnt[1] = 100; qqnt[2] = 100; qqnt[3] = 100;
        push(0, 100);
        for (int k = 0; k < 6; k++) push(1, 100);
        serve(1, -1, 1'b0, "R7 queue 0 first", g);
        serve(1, -1, 1'b0, "R7 queue 1 next", g);
        push(0, 250);
        serve(1, -1, 1'b0, "R7 refill waits for fresh credit", g);
        chk(g == 1, "R7 cleared credit forces extra round", g, 1);
        drain(1'b0, "R7 remainder");

        // R9: mode toggles mid-packet apply at the next boundary only.
        do_reset(1'b0);
        for (int i = 0; i < NQ; i++) begin
            qqnt[i] = 200;
            for (int k = 0; k < 4; k++) push(i, 100);
        end
        serve(2, -1, 1'b0, "R9 weighted start", g);
        serve(2, -1, 1'b0, "R9 weighted start", g);
        serve(4, 1, 1'b0, "R9 switch to strict", g);
        serve(2, -1, 1'b0, "R9 strict after switch", g);
        chk(g == 0, "R9 strict picks queue 0", g, 0);
        serve(4, 0, 1'b0, "R9 switch to weighted", g);
        drain(1'b0, "R9 weighted resumes untouched");

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule